// File: doc/BRIEF.md
# Synchronous Burst Static Memory with Byte-Lane Writes

This block is a single-clock static memory behind a burst control port. At each rising clock edge it reads a chip-select triple, a load/continue strobe, a write strobe, one write select per byte lane, a clock-enable and a sleep input. From these it opens a read or write burst, continues the burst at the next address, deselects, waits, or does nothing at all. The storage is an internal register array. Each lane holds eight data bits and one parity bit.

Read data comes combinationally from the address registered for the current cycle, so it appears in the same cycle the edge accepts (flow-through). The bidirectional bus is modelled as a data input, a data output and a drive-enable. The drive-enable follows an asynchronous, active-low output enable. That output enable is masked in write cycles, in deselected cycles and during sleep. A burst walks the two low address bits in linear order, wrapping modulo four, while the upper bits stay fixed.

Top module: `burst_sram`

## Requirements
- R1: With `adv_ld` low, the cycle is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A selected cycle loads `addr` as the cycle address and opens a read burst when `we_n`=1 or a write burst when `we_n`=0.
- R2: With `adv_ld` low and any other select combination, the cycle is deselected. Nothing is stored and `dout_en` is 0.
- R3: With `adv_ld` high, the chip selects and `we_n` are ignored. An open burst keeps its read or write type and steps its address: bits [1:0] increment modulo 4 and the upper bits are held. A deselected state stays deselected.
- R4: While `clk_en_n` is 1, the edge is ignored. The address, the operation and the output state hold, and nothing is stored.
- R5: While `sleep` is 1, every other input is ignored, nothing is stored and `dout_en` is 0.
- R6: In a write cycle, lane i is bits [9i+8:9i] of `din` (bit 9i+8 is its parity bit). It is stored only if `lane_wr_n[i]`=0. Any mix of lanes is allowed, and all ones stores nothing.
- R7: In a write cycle `dout_en` is 0 whatever the level of `oe_n`.
- R8: In a read cycle, `dout` holds the word at the current cycle address. `dout_en` equals the inverse of `oe_n` combinationally, with no clock edge needed.
- R9: After reset the block is deselected and `dout_en` is 0, even with `oe_n` at 0.
- R10: A read with `oe_n` high drives nothing, but the burst address still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Sleep; overrides all other inputs |
| clk_en_n | input | 1 | Clock enable, active low; high inserts a wait state |
| adv_ld | input | 1 | 0 = load a new cycle, 1 = continue the burst |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe at burst start, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 6 | Word address |
| din | input | 36 | Write data, 4 lanes of 9 bits |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a burst step that happens while nothing is visible. Such steps occur in a dummy read and across a stall. They can only be seen through the word read on the following cycle.

The stimulus therefore fills four wrapped addresses with distinct words. It then runs a read burst through a stall and a dummy read, and checks that the word read after each gap is the one at the correctly advanced address. Partial-lane merges, aborted writes and writes attempted under sleep or deselect are read back the same way.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              clk_en_n,
   input  logic              adv_ld,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output op_e               op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] wr_addr
);
   localparam int HI_W = ADDR_W - BURST_W;

   if (BURST_W < 1 || HI_W < 1) begin : g_bad_width
      $error("burst_sram_ctrl: ADDR_W must exceed BURST_W, BURST_W >= 1");
   end

   logic              live;
   logic              picked;
   op_e               op_d;
   logic [ADDR_W-1:0] addr_d;
   logic [ADDR_W-1:0] addr_step;

   assign live      = !sleep && !clk_en_n;
   assign picked    = !sel_a_n && sel_b && !sel_c_n;
   assign addr_step = {addr_q[ADDR_W-1:BURST_W], addr_q[BURST_W-1:0] + 1'b1};

   always_comb begin
      op_d   = op_q;
      addr_d = addr_q;
      if (!adv_ld) begin
         if (picked) begin
            op_d   = we_n ? OP_READ : OP_WRITE;
            addr_d = addr;
         end else begin
            op_d   = OP_IDLE;
         end
      end else if (op_q != OP_IDLE) begin
         addr_d = addr_step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
      end else if (live) begin
         op_q   <= op_d;
         addr_q <= addr_d;
      end
   end

   assign wr_fire = live && (op_d == OP_WRITE);
   assign wr_addr = addr_d;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(op_q) && $stable(addr_q)); // R4
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> $stable(op_q) && $stable(addr_q)); // R5
   AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !adv_ld && !sel_a_n && sel_b && !sel_c_n)
      |=> addr_q == $past(addr) && op_q == ($past(we_n) ? OP_READ : OP_WRITE)); // R1
   AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !adv_ld && !(!sel_a_n && sel_b && !sel_c_n)) |=> op_q == OP_IDLE); // R2
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (live && adv_ld && op_q != OP_IDLE)
      |=> addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + 1'b1
          && addr_q[ADDR_W-1:BURST_W] == $past(addr_q[ADDR_W-1:BURST_W])); // R3
   AST_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (live && adv_ld) |=> $stable(op_q)); // R3
endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (LANE_W < 1 || ADDR_W < 1) begin : g_bad_size
      $error("burst_sram_lane: LANE_W and ADDR_W must be positive");
   end

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   assign rd_data = cells[rd_addr];

   AST_LANE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cells[$past(wr_addr)] == $past(wr_data)); // R6
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int BYTE_W  = 8,
   parameter int PAR_W   = 1,
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              sleep,
   input  logic                              clk_en_n,
   input  logic                              adv_ld,
   input  logic                              sel_a_n,
   input  logic                              sel_b,
   input  logic                              sel_c_n,
   input  logic                              we_n,
   input  logic [LANES-1:0]                  lane_wr_n,
   input  logic                              oe_n,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [LANES*(BYTE_W+PAR_W)-1:0]   din,
   output logic [LANES*(BYTE_W+PAR_W)-1:0]   dout,
   output logic                              dout_en
);
   localparam int LANE_W = BYTE_W + PAR_W;

   if (LANES < 1 || BYTE_W < 1 || PAR_W < 0) begin : g_bad_cfg
      $error("burst_sram: LANES and BYTE_W must be positive, PAR_W non-negative");
   end

   op_e               op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_fire;
   logic [ADDR_W-1:0] wr_addr;

   burst_sram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .sleep    (sleep),
      .clk_en_n (clk_en_n),
      .adv_ld   (adv_ld),
      .sel_a_n  (sel_a_n),
      .sel_b    (sel_b),
      .sel_c_n  (sel_c_n),
      .we_n     (we_n),
      .addr     (addr),
      .op_q     (op_q),
      .addr_q   (addr_q),
      .wr_fire  (wr_fire),
      .wr_addr  (wr_addr)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      burst_sram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_fire && !lane_wr_n[g]),
         .wr_addr (wr_addr),
         .wr_data (din[g*LANE_W +: LANE_W]),
         .rd_addr (addr_q),
         .rd_data (dout[g*LANE_W +: LANE_W])
      );
   end

   assign dout_en = !sleep && (op_q == OP_READ) && !oe_n;

   AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_WRITE) |-> !dout_en); // R7
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_en); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_IDLE) |-> !dout_en); // R2
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic        slp, cen_n, adv, ce1_n, ce2, ce3_n, we_n;
      logic [3:0]  lane_n;
      logic        oe_n;
      logic [5:0]  a;
      logic [35:0] d;
      logic        en;
      logic [35:0] q;
      logic [7:0]  req;
   } vec_t;

   localparam logic [35:0] A0 = 36'h1A2B3C4D5, A1 = 36'h26E5D4C3B;
   localparam logic [35:0] A2 = 36'h3F0E1D2C3, A3 = 36'h412345678;
   localparam logic [35:0] BW = 36'hFEDCBA987, CW = 36'h0AAAAAAAA;
   localparam logic [35:0] M02 = 36'h007FC01FF;
   localparam logic [35:0] MRG = (BW & M02) | (A0 & ~M02);
   localparam int NV = 19;

   localparam vec_t VEC [NV] = '{
      // write burst from 0x05 wraps through 06,07,04 (R1, R3)
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'h05,A0,1'b0,36'h0,8'd1},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'h0,1'b0,6'h3F,A1,1'b0,36'h0,8'd3},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'h0,1'b0,6'h3F,A2,1'b0,36'h0,8'd3},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'h0,1'b0,6'h3F,A3,1'b0,36'h0,8'd7},
      // read burst (R1, R8, R3)
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h05,CW,1'b1,A0,8'd8},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,6'h00,CW,1'b1,A1,8'd3},
      // stall holds word (R4)
      '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,4'h0,1'b0,6'h00,CW,1'b1,A1,8'd4},
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'h00,CW,1'b1,A2,8'd3},
      // dummy read advances to 04 (R10), then 05 visible
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,6'h00,CW,1'b0,36'h0,8'd10},
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h00,CW,1'b1,A0,8'd10},
      // partial write lanes 0 and 2 (R6, R7)
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'b1010,1'b0,6'h05,BW,1'b0,36'h0,8'd7},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h05,CW,1'b1,MRG,8'd6},
      // deselect with write strobes, continue stays idle (R2, R3)
      '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'h0,1'b0,6'h05,CW,1'b0,36'h0,8'd2},
      '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'h0,1'b0,6'h05,CW,1'b0,36'h0,8'd3},
      '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,6'h05,CW,1'b0,36'h0,8'd2},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h05,CW,1'b1,MRG,8'd2},
      // sleep ignores a write (R5)
      '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'h05,CW,1'b0,36'h0,8'd5},
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h05,CW,1'b1,MRG,8'd5},
      // abort write (no lanes) then read back reset value (R6)
      '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'hF,1'b0,6'h08,CW,1'b0,36'h0,8'd6}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sleep = 1'b0, clk_en_n = 1'b0, adv_ld = 1'b0;
   logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1, we_n = 1'b1;
   logic [3:0]  lane_wr_n = 4'hF;
   logic        oe_n = 1'b0;
   logic [5:0]  addr = '0;
   logic [35:0] din = '0;
   logic [35:0] dout;
   logic        dout_en;
   int          n_chk = 0, n_bad = 0;
   logic        done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   burst_sram u_burst_sram (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
      .adv_ld(adv_ld), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .we_n(we_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n), .addr(addr),
      .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic check_en(input logic exp, input string req);
      n_chk++;
      if (dout_en !== exp) begin
         n_bad++;
         $display("FAIL %s dout_en actual %b expected %b", req, dout_en, exp);
      end
   endtask

   task automatic check_q(input logic [35:0] exp, input string req);
      n_chk++;
      if (dout !== exp) begin
         n_bad++;
         $display("FAIL %s dout actual %h expected %h", req, dout, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      sleep = v.slp; clk_en_n = v.cen_n; adv_ld = v.adv;
      sel_a_n = v.ce1_n; sel_b = v.ce2; sel_c_n = v.ce3_n; we_n = v.we_n;
      lane_wr_n = v.lane_n; oe_n = v.oe_n; addr = v.a; din = v.d;
   endtask

   task automatic step(input vec_t v);
      drive(v);
      @(posedge clk);
      @(negedge clk);
   endtask

   localparam vec_t WR10 = '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'h10,A0,1'b0,36'h0,8'd4};
   localparam vec_t STL  = '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'h00,A1,1'b0,36'h0,8'd4};
   localparam vec_t CWR  = '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,6'h00,A2,1'b0,36'h0,8'd4};
   localparam vec_t RD10 = '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h10,CW,1'b1,A0,8'd4};
   localparam vec_t CRD  = '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h00,CW,1'b1,A2,8'd4};
   localparam vec_t RD08 = '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h08,CW,1'b1,36'h0,8'd6};

   initial begin
      // R9: reset state with output enable asserted
      oe_n = 1'b0;
      repeat (3) @(negedge clk);
      check_en(1'b0, "R9");
      rst_n = 1'b1;
      @(negedge clk);
      clk_en_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check_en(1'b0, "R9");

      for (int i = 0; i < NV; i++) begin
         step(VEC[i]);
         n_chk++;
         if (dout_en !== VEC[i].en || (VEC[i].en && dout !== VEC[i].q)) begin
            n_bad++;
            $display("FAIL R%0d vector %0d actual en=%b q=%h expected en=%b q=%h",
                     VEC[i].req, i, dout_en, dout, VEC[i].en, VEC[i].q);
         end
      end

      // R6: aborted write left address 0x08 at reset value
      step(RD08);
      check_en(1'b1, "R6"); check_q(36'h0, "R6");

      // R8: output enable acts without a clock edge
      #1 oe_n = 1'b1;
      #1 check_en(1'b0, "R8");
      oe_n = 1'b0;
      #1 check_en(1'b1, "R8");
      // R5: sleep silences an active read immediately
      sleep = 1'b1;
      #1 check_en(1'b0, "R5");
      sleep = 1'b0;
      @(negedge clk);

      // R4: stall inside a write burst stores nothing and holds the address
      step(WR10);
      step(STL);
      step(CWR);
      step(RD10);
      check_en(1'b1, "R4"); check_q(A0, "R4");
      step(CRD);
      check_q(A2, "R4");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule